// File: doc/BRIEF.md
# Boot-Time Debug Lock Checker

This block decides, once after every reset and before the processor may run, whether debug access must be shut off. It walks the start of the flash image through a single-outstanding read port. It first fetches the eight 32-bit words of the exception vector table and checks that their wrapping sum is zero. It then fetches one configuration word from a fixed protection address. Debug is disabled only when the table sum is valid and the protection word holds the lock constant. In every other case debug stays available.

While the evaluation runs, the processor is held back. A release output rises only once the verdict is final, so the first instruction fetch from address 0 always follows the decision. After that, nothing except a full-chip-erase indication can drop the lock. An erase that arrives during an evaluation cancels it at once: debug stays enabled and the processor is released. Because erased flash reads as all ones, the next evaluation after an erase fails the table sum and leaves debug enabled.

Top module: `boot_dbg_lock`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dbg_disable`, `cpu_release` and `rd_req` are all 0.
- R2: An evaluation issues exactly nine reads. The first eight go to byte addresses 0x000, 0x004, up to 0x01C in ascending order, and the ninth goes to 0x1FC. `rd_req` is a one-cycle pulse, and no new request follows until `rd_valid` has answered the previous one.
- R3: A `rd_valid` pulse that arrives while no read is outstanding has no effect on the checksum or on the verdict.
- R4: The image is valid when the eight table words add up to zero modulo 2^32. Carries out of bit 31 are discarded.
- R5: When the image is valid and the word at 0x1FC equals 0x87654321, `dbg_disable` goes to 1 on the same clock edge on which `cpu_release` rises.
- R6: If the table sum is nonzero or the protection word differs from 0x87654321, `dbg_disable` stays 0 after release.
- R7: `cpu_release` stays 0 until all nine reads have completed and the verdict is taken. Once it is 1, it stays 1 until the next reset.
- R8: Once `dbg_disable` is 1, it stays 1 in every following cycle until `erase_done` or `rst` is seen.
- R9: A cycle with `erase_done` high makes `dbg_disable` 0 at the next edge. It stays 0 until the next reset.
- R10: `erase_done` during an evaluation ends it. `cpu_release` is 1 at the next edge, `dbg_disable` stays 0, and no further read is requested.
- R11: An all-ones image (erased flash, key word also all ones) gives a verdict with debug enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts a new evaluation when released |
| erase_done | input | 1 | Full-chip-erase completed; clears the lock and aborts a running evaluation |
| rd_req | output | 1 | One-cycle flash read request |
| rd_addr | output | 12 | Byte address of the requested word, held after the request |
| rd_valid | input | 1 | One-cycle pulse: `rd_data` carries the answer to the outstanding request |
| rd_data | input | 32 | Flash read data |
| dbg_disable | output | 1 | 1 when debug access is locked out |
| cpu_release | output | 1 | 1 when the processor may start executing |

## Verification
The assertions assume that the flash answers each request with exactly one `rd_valid` pulse, at least one cycle after the request, and that `erase_done` is synchronous to `clk`. The bench flash model keeps to this. It replies after one to three cycles, chosen per request. Its only deliberate departure is a junk `rd_valid` pulse placed in the idle cycle that follows a genuine answer, which is how R3 is exercised. The erase tests raise `erase_done` for a single cycle, both during the reads and after the verdict.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

    localparam int unsigned BDL_ADDR_W    = 12;
    localparam int unsigned BDL_DATA_W    = 32;
    localparam int unsigned BDL_VEC_WORDS = 8;
    localparam int unsigned BDL_KEY_ADDR  = 32'h0000_01FC;
    localparam longint unsigned BDL_KEY_VALUE = 64'h0000_0000_8765_4321;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_VEC  = 3'd1,
        ST_CHECK_SUM = 3'd2,
        ST_READ_KEY  = 3'd3,
        ST_DECIDE    = 3'd4,
        ST_DONE      = 3'd5
    } bdl_state_e;

    typedef struct packed {
        logic sum_ok;
        logic key_ok;
    } bdl_verdict_t;

    // Byte address of a vector-table word (32-bit words, byte addressed).
    function automatic int unsigned bdl_word_addr(input int unsigned idx);
        return idx * 4;
    endfunction

    function automatic logic bdl_grants_lock(input bdl_verdict_t v);
        return v.sum_ok & v.key_ok;
    endfunction

endpackage

// File: rtl/bdl_sum_acc.sv
module bdl_sum_acc #(
    parameter int unsigned DATA_W = bdl_pkg::BDL_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_clear,
    input  logic              acc_add,
    input  logic [DATA_W-1:0] acc_data,
    output logic              sum_zero
);

    logic [DATA_W-1:0] sum_q;

    // Wrapping sum: carries out of the top bit are dropped.
    always_ff @(posedge clk) begin
        if (rst || acc_clear) begin
            sum_q <= '0;
        end else if (acc_add) begin
            sum_q <= sum_q + acc_data;
        end
    end

    assign sum_zero = (sum_q == '0);

    // R4: a cleared accumulator reads as a zero sum
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        acc_clear |=> sum_zero);

endmodule

// File: rtl/bdl_seq.sv
module bdl_seq
    import bdl_pkg::*;
#(
    parameter int unsigned     ADDR_W    = BDL_ADDR_W,
    parameter int unsigned     DATA_W    = BDL_DATA_W,
    parameter int unsigned     VEC_WORDS = BDL_VEC_WORDS,
    parameter int unsigned     KEY_ADDR  = BDL_KEY_ADDR,
    parameter longint unsigned KEY_VALUE = BDL_KEY_VALUE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              sum_zero,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              acc_clear,
    output logic              acc_add,
    output logic              set_lock,
    output logic              cpu_release
);

    localparam int unsigned       IDX_W    = (VEC_WORDS > 1) ? $clog2(VEC_WORDS) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(VEC_WORDS - 1);
    localparam logic [ADDR_W-1:0] KEY_A    = ADDR_W'(KEY_ADDR);
    localparam logic [DATA_W-1:0] KEY_V    = DATA_W'(KEY_VALUE);

    bdl_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             pending_q;
    bdl_verdict_t     verdict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            pending_q <= 1'b0;
            rd_req    <= 1'b0;
            rd_addr   <= '0;
            verdict_q <= '0;
        end else begin
            rd_req <= 1'b0;
            if (erase && state_q != ST_DONE) begin
                // Abort: no further reads, release with debug left enabled.
                state_q   <= ST_DONE;
                pending_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        idx_q     <= '0;
                        pending_q <= 1'b0;
                        verdict_q <= '0;
                        state_q   <= ST_READ_VEC;
                    end
                    ST_READ_VEC: begin
                        if (!pending_q) begin
                            rd_req    <= 1'b1;
                            rd_addr   <= ADDR_W'(bdl_word_addr(32'(idx_q)));
                            pending_q <= 1'b1;
                        end else if (rd_valid) begin
                            pending_q <= 1'b0;
                            if (idx_q == LAST_IDX) begin
                                state_q <= ST_CHECK_SUM;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_CHECK_SUM: begin
                        verdict_q.sum_ok <= sum_zero;
                        state_q          <= ST_READ_KEY;
                    end
                    ST_READ_KEY: begin
                        if (!pending_q) begin
                            rd_req    <= 1'b1;
                            rd_addr   <= KEY_A;
                            pending_q <= 1'b1;
                        end else if (rd_valid) begin
                            pending_q        <= 1'b0;
                            verdict_q.key_ok <= (rd_data == KEY_V);
                            state_q          <= ST_DECIDE;
                        end
                    end
                    ST_DECIDE: state_q <= ST_DONE;
                    default:   state_q <= ST_DONE;
                endcase
            end
        end
    end

    assign acc_clear   = (state_q == ST_IDLE);
    assign acc_add     = (state_q == ST_READ_VEC) && pending_q && rd_valid && !erase;
    assign set_lock    = (state_q == ST_DECIDE) && bdl_grants_lock(verdict_q) && !erase;
    assign cpu_release = (state_q == ST_DONE);

    // R2: a request is a single-cycle pulse
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R2: requested addresses are word aligned
    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    // R7: release is held until reset
    a_r7_release_hold: assert property (@(posedge clk) disable iff (rst)
        cpu_release |=> cpu_release);

    // R10: no flash traffic once the processor is released
    a_r10_quiet_after_release: assert property (@(posedge clk) disable iff (rst)
        cpu_release |-> !rd_req);

    // R10: erase during evaluation releases at the next edge
    a_r10_erase_release: assert property (@(posedge clk) disable iff (rst)
        (erase && !cpu_release) |=> cpu_release);

endmodule

// File: rtl/bdl_lock.sv
module bdl_lock (
    input  logic clk,
    input  logic rst,
    input  logic set_lock,
    input  logic erase,
    output logic locked
);

    // Erase wins over a same-cycle set; nothing else can clear the lock.
    always_ff @(posedge clk) begin
        if (rst || erase) begin
            locked <= 1'b0;
        end else if (set_lock) begin
            locked <= 1'b1;
        end
    end

    // R8: the lock holds until erase or reset
    a_r8_lock_hold: assert property (@(posedge clk) disable iff (rst)
        (locked && !erase) |=> locked);

    // R9: erase clears the lock at the next edge
    a_r9_erase_clear: assert property (@(posedge clk) disable iff (rst)
        erase |=> !locked);

endmodule

// File: rtl/boot_dbg_lock.sv
module boot_dbg_lock
    import bdl_pkg::*;
#(
    parameter int unsigned     ADDR_W    = BDL_ADDR_W,
    parameter int unsigned     DATA_W    = BDL_DATA_W,
    parameter int unsigned     VEC_WORDS = BDL_VEC_WORDS,
    parameter int unsigned     KEY_ADDR  = BDL_KEY_ADDR,
    parameter longint unsigned KEY_VALUE = BDL_KEY_VALUE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_done,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              dbg_disable,
    output logic              cpu_release
);

    logic acc_clear;
    logic acc_add;
    logic sum_zero;
    logic set_lock;

    bdl_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_WORDS(VEC_WORDS),
        .KEY_ADDR (KEY_ADDR),
        .KEY_VALUE(KEY_VALUE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .erase      (erase_done),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .sum_zero   (sum_zero),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .acc_clear  (acc_clear),
        .acc_add    (acc_add),
        .set_lock   (set_lock),
        .cpu_release(cpu_release)
    );

    bdl_sum_acc #(
        .DATA_W(DATA_W)
    ) u_sum (
        .clk      (clk),
        .rst      (rst),
        .acc_clear(acc_clear),
        .acc_add  (acc_add),
        .acc_data (rd_data),
        .sum_zero (sum_zero)
    );

    bdl_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .set_lock(set_lock),
        .erase   (erase_done),
        .locked  (dbg_disable)
    );

    // R5: the lock appears together with the release, never before it
    a_r5_lock_with_release: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_disable) |-> $rose(cpu_release));

endmodule

// File: tb/boot_dbg_lock_bench.sv
`timescale 1ns/1ps
module boot_dbg_lock_bench;

    localparam logic [31:0] MAGIC = 32'h8765_4321;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        erase_done = 1'b0;
    logic        rd_req;
    logic [11:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        dbg_disable;
    logic        cpu_release;

    int tests_run = 0;
    int tests_failed = 0;

    logic [31:0] img [0:7];
    logic [31:0] key_word;
    logic [11:0] req_log [0:15];
    int          req_cnt = 0;
    bit          inject_junk = 1'b0;

    always #2.5 clk = ~clk;

    boot_dbg_lock u_boot_dbg_lock (
        .clk        (clk),
        .rst        (rst),
        .erase_done (erase_done),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dbg_disable(dbg_disable),
        .cpu_release(cpu_release)
    );

    function automatic logic [31:0] flash_word(input logic [11:0] a);
        if (a < 12'h020) return img[a[4:2]];
        if (a == 12'h1FC) return key_word;
        return 32'hFFFF_FFFF;
    endfunction

    // Flash model: one answer per request after 1..3 cycles, optional junk after it.
    initial begin
        int          cnt = 0;
        bit          junk_next = 1'b0;
        logic [11:0] hold = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rst) begin
                cnt = 0;
                junk_next = 1'b0;
                req_cnt = 0;
            end else begin
                if (junk_next) begin
                    rd_valid = 1'b1;
                    rd_data = 32'h1357_9BDF;
                    junk_next = 1'b0;
                end
                if (cnt > 0) begin
                    cnt--;
                    if (cnt == 0) begin
                        rd_valid = 1'b1;
                        rd_data = flash_word(hold);
                        junk_next = inject_junk;
                    end
                end
                if (rd_req) begin
                    hold = rd_addr;
                    if (req_cnt < 16) req_log[req_cnt] = rd_addr;
                    req_cnt++;
                    cnt = 1 + (req_cnt % 3);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        erase_done = 1'b0;
        repeat (3) @(negedge clk);
        check(dbg_disable == 1'b0 && cpu_release == 1'b0 && rd_req == 1'b0, "R1",
              "outputs in reset", {29'd0, dbg_disable, cpu_release, rd_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(dbg_disable == 1'b0 && cpu_release == 1'b0 && rd_req == 1'b0, "R1",
              "outputs after reset", {29'd0, dbg_disable, cpu_release, rd_req}, 32'd0);
    endtask

    task automatic wait_release(input string tag);
        bit early = 1'b0;
        for (int i = 0; i < 300 && !cpu_release; i++) begin
            if (dbg_disable) early = 1'b1;
            @(negedge clk);
        end
        check(cpu_release == 1'b1, tag, "release reached", {31'd0, cpu_release}, 32'd1);
        check(!early, "R5", "no lock before release", {31'd0, early}, 32'd0);
    endtask

    task automatic make_good_image();
        logic [31:0] s = '0;
        for (int i = 0; i < 7; i++) begin
            img[i] = 32'h0000_0040 + 32'(i) * 32'h0001_1111;
            s += img[i];
        end
        img[7] = -s;
        key_word = MAGIC;
    endtask

    task automatic t_lock_good();
        make_good_image();
        do_reset();
        wait_release("R7");
        check(req_cnt == 9, "R7", "all reads done before release", 32'(req_cnt), 32'd9);
        for (int i = 0; i < 8; i++)
            check(req_log[i] == 12'(i * 4), "R2", "vector read address",
                  {20'd0, req_log[i]}, 32'(i * 4));
        check(req_log[8] == 12'h1FC, "R2", "key read address", {20'd0, req_log[8]}, 32'h1FC);
        check(dbg_disable == 1'b1, "R5", "lock after good image", {31'd0, dbg_disable}, 32'd1);
        repeat (40) @(negedge clk);
        check(dbg_disable == 1'b1 && cpu_release == 1'b1, "R8", "lock and release hold",
              {30'd0, dbg_disable, cpu_release}, 32'd3);
        check(req_cnt == 9, "R2", "no reads after verdict", 32'(req_cnt), 32'd9);
    endtask

    task automatic t_bad_sum();
        make_good_image();
        img[3] = img[3] + 32'd1;
        do_reset();
        wait_release("R6");
        check(dbg_disable == 1'b0, "R6", "bad sum keeps debug", {31'd0, dbg_disable}, 32'd0);
    endtask

    task automatic t_wrong_key();
        make_good_image();
        key_word = 32'h8765_4320;
        do_reset();
        wait_release("R6");
        check(dbg_disable == 1'b0, "R6", "wrong key keeps debug", {31'd0, dbg_disable}, 32'd0);
    endtask

    task automatic t_wrap_sum();
        for (int i = 0; i < 7; i++) img[i] = 32'hFFFF_FFFF;
        img[7] = 32'h0000_0007;
        key_word = MAGIC;
        do_reset();
        wait_release("R4");
        check(dbg_disable == 1'b1, "R4", "wrapping sum accepted", {31'd0, dbg_disable}, 32'd1);
    endtask

    task automatic t_junk_valid();
        make_good_image();
        inject_junk = 1'b1;
        do_reset();
        wait_release("R3");
        inject_junk = 1'b0;
        check(req_cnt == 9, "R3", "read count with junk valids", 32'(req_cnt), 32'd9);
        check(dbg_disable == 1'b1, "R3", "junk valids ignored", {31'd0, dbg_disable}, 32'd1);
    endtask

    task automatic t_erase_after_lock();
        make_good_image();
        do_reset();
        wait_release("R9");
        check(dbg_disable == 1'b1, "R9", "locked before erase", {31'd0, dbg_disable}, 32'd1);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        check(dbg_disable == 1'b0, "R9", "erase clears lock", {31'd0, dbg_disable}, 32'd0);
        repeat (20) @(negedge clk);
        check(dbg_disable == 1'b0 && cpu_release == 1'b1, "R9", "lock stays cleared",
              {30'd0, dbg_disable, cpu_release}, 32'd1);
    endtask

    task automatic t_erase_abort();
        int snap;
        make_good_image();
        do_reset();
        for (int i = 0; i < 100 && req_cnt < 3; i++) @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        check(cpu_release == 1'b1, "R10", "abort releases", {31'd0, cpu_release}, 32'd1);
        check(dbg_disable == 1'b0, "R10", "abort leaves debug", {31'd0, dbg_disable}, 32'd0);
        @(negedge clk);
        snap = req_cnt;
        repeat (30) @(negedge clk);
        check(req_cnt == snap, "R10", "no reads after abort", 32'(req_cnt), 32'(snap));
        check(dbg_disable == 1'b0, "R10", "no late lock", {31'd0, dbg_disable}, 32'd0);
    endtask

    task automatic t_erased_flash();
        for (int i = 0; i < 8; i++) img[i] = 32'hFFFF_FFFF;
        key_word = 32'hFFFF_FFFF;
        do_reset();
        wait_release("R11");
        check(dbg_disable == 1'b0, "R11", "erased image unlocked", {31'd0, dbg_disable}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        t_lock_good();
        t_bad_sum();
        t_wrong_key();
        t_wrap_sum();
        t_junk_valid();
        t_erase_after_lock();
        t_erase_abort();
        t_erased_flash();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule